// File: doc/BRIEF.md
# ADC Channel Scan Sequencer

This block walks an analog multiplexer select through a contiguous run of input channels, moving one step for every accepted conversion trigger. Software programs the run with a single 16-bit write that packs a first and a last channel. Each accepted trigger copies the current channel onto the select output and raises a one-cycle conversion-start strobe. It then moves the internal pointer to the next channel, and the pointer goes back to the first channel once the last channel has been used.

A small mode register chooses where triggers come from: a software start pulse, a falling edge on an external pin, a rising edge on that pin, or a tick from an external pacer. The same register also holds a differential flag. In differential mode only channels up to half the channel count are legal. The converter, the sample buffer and the pacer timer sit outside this block.

The control core is a two-state machine. ST_WAIT means no conversion is starting in the current cycle. ST_FIRE means the strobe is high. The transition WAIT→FIRE is taken on an accepted trigger. FIRE→FIRE is taken when another trigger is accepted in the next cycle. FIRE→WAIT is taken when no trigger is accepted. A trigger is accepted only in a cycle with no range write.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset, chan_sel is 0, conv_start is 0, both range bounds are channel 0, the trigger source is software and differential mode is off.
- R2: A range write takes the first channel from range_data[5:0] and the last channel from range_data[13:8], and it sends the scan pointer back to the first channel, so the next conversion uses the first channel.
- R3: An accepted trigger makes conv_start high for the following cycle, with chan_sel showing the current pointer channel during that cycle. The pointer then moves up by one.
- R4: A conversion on the last channel is followed by a conversion on the first channel.
- R5: Equal first and last channels give repeated conversions of that one channel.
- R6: If the first channel is greater than the last, every conversion uses the first channel.
- R7: When trig_sel (mode_data[1:0]) is 0, each cycle with soft_start high is a trigger, and ext_trig and pacer_tick are ignored.
- R8: When trig_sel is 1, a falling edge of ext_trig is a trigger. After two synchronizer flops and the edge detector, conv_start rises on the third clock edge after the change. Rising edges are ignored.
- R9: When trig_sel is 2, a rising edge of ext_trig is a trigger with the same latency, and falling edges are ignored.
- R10: When trig_sel is 3, each cycle with pacer_tick high is a trigger, and soft_start is ignored.
- R11: When differential mode (mode_data[2]) is set, any bound above NUM_CH/2 (32) acts as NUM_CH/2.
- R12: A trigger that arrives in the same cycle as a range write is dropped.
- R13: Triggers in consecutive cycles give consecutive conversions, with conv_start staying high and chan_sel advancing every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| range_wr | input | 1 | Write strobe for the range register |
| range_data | input | 16 | First channel in [5:0], last channel in [13:8] |
| mode_wr | input | 1 | Write strobe for the mode register |
| mode_data | input | 3 | [1:0] trigger source, [2] differential mode |
| soft_start | input | 1 | Software conversion request |
| ext_trig | input | 1 | Asynchronous external trigger pin |
| pacer_tick | input | 1 | Pacer trigger pulse |
| chan_sel | output | 6 | Multiplexer channel select |
| conv_start | output | 1 | Conversion-start strobe |

## Verification
The bench goes after the wrap point, and a design that got it wrong would run past the last channel or skip back one step early. It also covers the reversed range, where a naive pointer would count upward through unrelated channels, and the clamp in differential mode, where a design without it would present channels above 32. It also checks the cycle in which a range write and a trigger coincide, where a wrong priority would start a conversion on a stale channel. Finally it exercises the two edge modes and the ignored sources, where a design with the wrong polarity or a leaky trigger mux would strobe on the wrong stimulus or at the wrong latency.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

    typedef enum logic [1:0] {
        TRIG_SOFT  = 2'd0,
        TRIG_FALL  = 2'd1,
        TRIG_RISE  = 2'd2,
        TRIG_PACER = 2'd3
    } trig_src_e;

    typedef enum logic {
        ST_WAIT = 1'b0,
        ST_FIRE = 1'b1
    } scan_state_e;

endpackage

// File: rtl/scan_edge_det.sv
module scan_edge_det #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], din};
            prev_q <= sync_q[STAGES-1];
        end
    end

    always_comb begin
        rise = sync_q[STAGES-1] & ~prev_q;
        fall = ~sync_q[STAGES-1] & prev_q;
    end

    // R9
    rise_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
    // R8
    fall_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);

endmodule

// File: rtl/scan_trig_mux.sv
module scan_trig_mux
    import adc_scan_pkg::*;
(
    input  trig_src_e trig_sel,
    input  logic      soft_start,
    input  logic      ext_rise,
    input  logic      ext_fall,
    input  logic      pacer_tick,
    output logic      fire
);
    always_comb begin
        unique case (trig_sel)
            TRIG_SOFT:  fire = soft_start;
            TRIG_FALL:  fire = ext_fall;
            TRIG_RISE:  fire = ext_rise;
            TRIG_PACER: fire = pacer_tick;
            default:    fire = 1'b0;
        endcase
    end
endmodule

// File: rtl/scan_fsm.sv
module scan_fsm
    import adc_scan_pkg::*;
#(
    parameter int NUM_CH = 64,
    parameter int CH_W   = $clog2(NUM_CH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            range_wr,
    input  logic [CH_W-1:0] first_in,
    input  logic [CH_W-1:0] last_in,
    input  logic            diff_mode,
    input  logic            fire,
    output logic [CH_W-1:0] chan_sel,
    output logic            conv_start
);
    localparam logic [CH_W-1:0] HALF = CH_W'(NUM_CH / 2);

    scan_state_e     state_q, state_d;
    logic [CH_W-1:0] first_q, last_q, ptr_q, chan_q;
    logic [CH_W-1:0] eff_first, eff_last, cur, nxt;
    logic            accept;

    always_comb begin
        eff_first = (diff_mode && first_q > HALF) ? HALF : first_q;
        eff_last  = (diff_mode && last_q  > HALF) ? HALF : last_q;
        cur       = (ptr_q < eff_first || ptr_q > eff_last) ? eff_first : ptr_q;
        nxt       = (cur >= eff_last) ? eff_first : cur + CH_W'(1);
        accept    = fire && !range_wr;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT: if (accept)  state_d = ST_FIRE;
            ST_FIRE: if (!accept) state_d = ST_WAIT;
            default: state_d = ST_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_WAIT;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_q <= '0;
            last_q  <= '0;
            ptr_q   <= '0;
            chan_q  <= '0;
        end else if (range_wr) begin
            first_q <= first_in;
            last_q  <= last_in;
            ptr_q   <= first_in;
        end else if (accept) begin
            chan_q <= cur;
            ptr_q  <= nxt;
        end
    end

    always_comb begin
        conv_start = (state_q == ST_FIRE);
        chan_sel   = chan_q;
    end

    // R4 R6 R11
    chan_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FIRE) |->
            (chan_q >= eff_first) && (eff_first > eff_last || chan_q <= eff_last));
    // R12
    write_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        range_wr |=> (state_q == ST_WAIT));

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
    import adc_scan_pkg::*;
#(
    parameter int NUM_CH      = 64,
    parameter int SYNC_STAGES = 2,
    localparam int CH_W       = $clog2(NUM_CH),
    localparam int LAST_LSB   = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            range_wr,
    input  logic [15:0]     range_data,
    input  logic            mode_wr,
    input  logic [2:0]      mode_data,
    input  logic            soft_start,
    input  logic            ext_trig,
    input  logic            pacer_tick,
    output logic [CH_W-1:0] chan_sel,
    output logic            conv_start
);
    trig_src_e trig_q;
    logic      diff_q;
    logic      ext_rise, ext_fall, fire;
    logic      unused_bits;

    assign unused_bits = ^{range_data[15:LAST_LSB+CH_W], range_data[LAST_LSB-1:CH_W]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_q <= TRIG_SOFT;
            diff_q <= 1'b0;
        end else if (mode_wr) begin
            trig_q <= trig_src_e'(mode_data[1:0]);
            diff_q <= mode_data[2];
        end
    end

    scan_edge_det #(.STAGES(SYNC_STAGES)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (ext_trig),
        .rise (ext_rise),
        .fall (ext_fall)
    );

    scan_trig_mux u_mux (
        .trig_sel  (trig_q),
        .soft_start(soft_start),
        .ext_rise  (ext_rise),
        .ext_fall  (ext_fall),
        .pacer_tick(pacer_tick),
        .fire      (fire)
    );

    scan_fsm #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .range_wr  (range_wr),
        .first_in  (range_data[CH_W-1:0]),
        .last_in   (range_data[LAST_LSB +: CH_W]),
        .diff_mode (diff_q),
        .fire      (fire),
        .chan_sel  (chan_sel),
        .conv_start(conv_start)
    );

    // R7
    soft_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_q == TRIG_SOFT && !soft_start) |=> !conv_start);
    // R10
    pacer_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_q == TRIG_PACER && !pacer_tick) |=> !conv_start);
    // R3
    strobe_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> !conv_start);

endmodule

// File: tb/adc_scan_seq_tb.sv
`timescale 1ns/100ps
module adc_scan_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        range_wr = 1'b0;
    logic [15:0] range_data = '0;
    logic        mode_wr = 1'b0;
    logic [2:0]  mode_data = '0;
    logic        soft_start = 1'b0;
    logic        ext_trig = 1'b0;
    logic        pacer_tick = 1'b0;
    logic [5:0]  chan_sel;
    logic        conv_start;
    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    adc_scan_seq u_dut (
        .clk(clk), .rst_n(rst_n), .range_wr(range_wr), .range_data(range_data),
        .mode_wr(mode_wr), .mode_data(mode_data), .soft_start(soft_start),
        .ext_trig(ext_trig), .pacer_tick(pacer_tick),
        .chan_sel(chan_sel), .conv_start(conv_start)
    );

    // entry: {op[1:0], data[15:0], expected channel[5:0]}
    // op 0 = range write, 1 = software start then check, 2 = mode write
    localparam int NV = 25;
    localparam logic [23:0] VEC [NV] = '{
        {2'd0, 16'h0502, 6'd0},                       // R2 first 2 last 5
        {2'd1, 16'h0, 6'd2}, {2'd1, 16'h0, 6'd3},     // R3
        {2'd1, 16'h0, 6'd4}, {2'd1, 16'h0, 6'd5},
        {2'd1, 16'h0, 6'd2},                          // R4 wrap
        {2'd0, 16'h0707, 6'd0},
        {2'd1, 16'h0, 6'd7}, {2'd1, 16'h0, 6'd7},     // R5
        {2'd0, 16'h030A, 6'd0},
        {2'd1, 16'h0, 6'd10}, {2'd1, 16'h0, 6'd10},   // R6
        {2'd2, 16'h0004, 6'd0},                       // differential on
        {2'd0, 16'h3F30, 6'd0},
        {2'd1, 16'h0, 6'd32}, {2'd1, 16'h0, 6'd32},   // R11 both clamp
        {2'd0, 16'h3F1F, 6'd0},
        {2'd1, 16'h0, 6'd31}, {2'd1, 16'h0, 6'd32},   // R11 last clamps
        {2'd1, 16'h0, 6'd31},
        {2'd2, 16'h0000, 6'd0},
        {2'd0, 16'h3F3E, 6'd0},
        {2'd1, 16'h0, 6'd62}, {2'd1, 16'h0, 6'd63},   // R4 top of space
        {2'd1, 16'h0, 6'd62}
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr_range(input logic [15:0] d);
        @(negedge clk); range_wr = 1'b1; range_data = d;
        @(negedge clk); range_wr = 1'b0;
    endtask

    task automatic wr_mode(input logic [2:0] d);
        @(negedge clk); mode_wr = 1'b1; mode_data = d;
        @(negedge clk); mode_wr = 1'b0;
    endtask

    task automatic soft_check(input string tag, input int exp_conv, input int exp_chan);
        @(negedge clk); soft_start = 1'b1;
        @(negedge clk); soft_start = 1'b0;
        chk({tag, " conv_start"}, conv_start, exp_conv);
        if (exp_conv == 1) chk({tag, " chan_sel"}, chan_sel, exp_chan);
    endtask

    task automatic quiet(input string tag, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(tag, conv_start, 0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 reset chan_sel", chan_sel, 0);
        chk("R1 reset conv_start", conv_start, 0);
        soft_check("R1 default software trigger channel 0", 1, 0);
        soft_check("R1 default range stays at 0", 1, 0);

        for (int v = 0; v < NV; v++) begin
            case (VEC[v][23:22])
                2'd0: wr_range(VEC[v][21:6]);
                2'd2: wr_mode(VEC[v][8:6]);
                default: soft_check($sformatf("R3/R4/R5/R6/R11 table vec %0d", v), 1, VEC[v][5:0]);
            endcase
        end

        // R2: range write mid-scan returns to the first channel
        wr_range(16'h0502);
        soft_check("R2 first", 1, 2);
        soft_check("R2 second", 1, 3);
        wr_range(16'h0502);
        soft_check("R2 restart at first", 1, 2);

        // R12: trigger coinciding with range write is dropped
        @(negedge clk); range_wr = 1'b1; range_data = 16'h0909; soft_start = 1'b1;
        @(negedge clk); range_wr = 1'b0; soft_start = 1'b0;
        chk("R12 dropped trigger", conv_start, 0);
        soft_check("R12 new first channel", 1, 9);

        // R13: back-to-back triggers
        wr_range(16'h0200);
        @(negedge clk); soft_start = 1'b1;
        @(negedge clk); chk("R13 conv 1", conv_start, 1); chk("R13 chan 0", chan_sel, 0);
        @(negedge clk); chk("R13 conv 2", conv_start, 1); chk("R13 chan 1", chan_sel, 1);
        @(negedge clk); chk("R13 conv 3", conv_start, 1); chk("R13 chan 2", chan_sel, 2);
        soft_start = 1'b0;
        @(negedge clk); chk("R13 ends", conv_start, 0);

        // R7: software mode ignores pin and pacer
        wr_range(16'h0404);
        @(negedge clk); pacer_tick = 1'b1; ext_trig = 1'b1;
        @(negedge clk); pacer_tick = 1'b0;
        quiet("R7 ignores ext/pacer", 4);
        ext_trig = 1'b0;
        quiet("R7 ignores ext fall", 5);

        // R8: falling edge mode
        wr_mode(3'd1);
        ext_trig = 1'b1;
        quiet("R8 rising ignored", 5);
        ext_trig = 1'b0;
        @(negedge clk);
        @(negedge clk); chk("R8 not before third edge", conv_start, 0);
        @(negedge clk); chk("R8 fall strobe", conv_start, 1); chk("R8 chan", chan_sel, 4);
        @(negedge clk); chk("R8 single pulse", conv_start, 0);
        soft_check("R8 soft ignored", 0, 0);

        // R9: rising edge mode
        wr_mode(3'd2);
        ext_trig = 1'b1;
        @(negedge clk);
        @(negedge clk); chk("R9 not before third edge", conv_start, 0);
        @(negedge clk); chk("R9 rise strobe", conv_start, 1); chk("R9 chan", chan_sel, 4);
        @(negedge clk); chk("R9 single pulse", conv_start, 0);
        ext_trig = 1'b0;
        quiet("R9 falling ignored", 5);

        // R10: pacer mode
        wr_mode(3'd3);
        soft_check("R10 soft ignored", 0, 0);
        wr_range(16'h0B0A);
        @(negedge clk); pacer_tick = 1'b1;
        @(negedge clk); pacer_tick = 1'b0;
        chk("R10 pacer strobe", conv_start, 1); chk("R10 chan", chan_sel, 10);
        @(negedge clk); pacer_tick = 1'b1;
        @(negedge clk); pacer_tick = 1'b0;
        chk("R10 pacer advances", chan_sel, 11);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule